// File: doc/BRIEF.md
# Load Queue with Snoop-Driven Replay

This block tracks loads that a core has executed ahead of program order, so that the core can still appear sequentially consistent to other processors. The dispatch stage reserves a slot for every load in program order. When the load's address is known, the execute stage writes the cache-line part of that address into its slot. Every write or upgrade seen on the coherence bus is compared at the same time against all slots that hold an address. Each slot that matches is marked, because the value it read may be stale.

The commit stage asks to retire the oldest load. An executed, unmarked oldest load retires at once and frees its slot. A marked oldest load instead raises a flush: the core re-runs that load and everything younger, and the queue empties completely in the next cycle. The queue asserts full so that dispatch stalls when no slot is free. The block carries no load data and does not perform the flush itself.

Top module: `lq_snoop_replay`

## Requirements
- R1: After reset the queue is empty: `empty`=1, `full`=0, `allocIdx`=0, `headIdx`=0, and a commit request raises neither `retireOk` nor `flush`.
- R2: Each accepted `allocValid` takes the slot shown on `allocIdx`, and `allocIdx` then advances by one modulo DEPTH. With DEPTH loads outstanding `full`=1, and `allocValid` is ignored. `allocValid` is also ignored in a cycle that raises `flush`.
- R3: `snoopKind` encodes 2'b01 as bus write and 2'b10 as bus upgrade, and both of these mark matching entries. 2'b00 (bus read) and 2'b11 (no operation) mark nothing.
- R4: Addresses are compared on bits [AW-1:OFFW] only, so a snoop to any byte of a load's line matches it.
- R5: One marking snoop marks every executed entry whose line matches, in the same cycle.
- R6: A slot that is reserved but not yet executed is never marked. A snoop that arrives before the load executes leaves that load unmarked once it does execute.
- R7: A marking snoop in the same cycle as `execValid` for a matching slot marks that slot.
- R8: While `commitValid`=1, an executed, unmarked oldest load raises `retireOk` in that cycle. In the next cycle `headIdx` has advanced by one modulo DEPTH and the slot is free.
- R9: While `commitValid`=1, a marked oldest load raises `flush` in that cycle and not `retireOk`. In the next cycle the queue is empty, with both pointers at 0.
- R10: A commit request while the queue is empty, or while the oldest load has not executed, raises neither output and leaves the queue unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| allocValid | input | 1 | Reserve a slot for the next load in program order |
| allocIdx | output | IW | Slot the next reservation takes |
| full | output | 1 | All slots are occupied, so dispatch must stall |
| empty | output | 1 | No slot is occupied |
| headIdx | output | IW | Slot of the oldest load |
| execValid | input | 1 | A load has computed its address |
| execIdx | input | IW | Slot of that load |
| execAddr | input | AW | Byte address of that load |
| snoopValid | input | 1 | A coherence transaction is observed |
| snoopKind | input | 2 | 00 read, 01 write, 10 upgrade, 11 no operation |
| snoopAddr | input | AW | Byte address of the transaction |
| commitValid | input | 1 | Commit asks to retire the oldest load |
| retireOk | output | 1 | The oldest load retires this cycle |
| flush | output | 1 | The oldest load was hit by a snoop, so the pipeline must be flushed |

## Verification
The hardest cases to reach are the ones where a snoop lines up exactly with another event: it arrives in the same cycle as the address it must catch, it hits a slot that is reserved but not yet executed, or it hits several slots at once while the pointers have wrapped. The bench first steps through each snoop kind against every line offset in directed runs. It then drives several thousand cycles of stimulus from a shift register, with addresses drawn from only four lines, so that these coincidences happen often. A cycle-level model of the requirements checks every output in every cycle.

// File: rtl/lqsr_pkg.sv
package lqsr_pkg;
  typedef enum logic [1:0] {
    SNP_READ    = 2'b00,
    SNP_WRITE   = 2'b01,
    SNP_UPGRADE = 2'b10,
    SNP_NONE    = 2'b11
  } snoop_kind_e;

  typedef struct packed {
    logic allocEn;
    logic retireEn;
    logic clearAll;
  } lq_strobe_t;
endpackage

// File: rtl/lqsr_entries.sv
module lqsr_entries
  import lqsr_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int OFFW  = 4,
  parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  lq_strobe_t       strobe,
  input  logic [IW-1:0]    allocPtr,
  input  logic [IW-1:0]    retirePtr,
  input  logic             execValid,
  input  logic [IW-1:0]    execIdx,
  input  logic [AW-1:0]    execAddr,
  input  logic             snoopValid,
  input  logic [1:0]       snoopKind,
  input  logic [AW-1:0]    snoopAddr,
  output logic [DEPTH-1:0] addrVec,
  output logic [DEPTH-1:0] markVec
);
  localparam int LW = AW - OFFW;

  logic [DEPTH-1:0] busyVec;
  logic [LW-1:0]    lineMem [DEPTH];
  logic [LW-1:0]    execLine, snoopLine;
  logic             snoopMarks;

  assign execLine   = execAddr[AW-1:OFFW];
  assign snoopLine  = snoopAddr[AW-1:OFFW];
  assign snoopMarks = snoopValid &&
                      (snoopKind == SNP_WRITE || snoopKind == SNP_UPGRADE);

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic          execHere, effHas, hit;
    logic [LW-1:0] effLine;

    assign execHere = execValid && (execIdx == IW'(i)) && busyVec[i];
    assign effHas   = addrVec[i] || execHere;
    assign effLine  = execHere ? execLine : lineMem[i];
    assign hit      = snoopMarks && busyVec[i] && effHas && (effLine == snoopLine);

    always_ff @(posedge clk) begin
      if (!rstN || strobe.clearAll) begin
        busyVec[i] <= 1'b0;
        addrVec[i] <= 1'b0;
        markVec[i] <= 1'b0;
      end else if (strobe.retireEn && retirePtr == IW'(i)) begin
        busyVec[i] <= 1'b0;
        addrVec[i] <= 1'b0;
        markVec[i] <= 1'b0;
      end else if (strobe.allocEn && allocPtr == IW'(i)) begin
        busyVec[i] <= 1'b1;
        addrVec[i] <= 1'b0;
        markVec[i] <= 1'b0;
      end else begin
        if (execHere) addrVec[i] <= 1'b1;
        if (hit)      markVec[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (execHere) lineMem[i] <= execLine;
    end
  end

  // R6: only executed entries can carry a replay mark
  p_mark_needs_addr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (markVec & ~addrVec) == '0);

  // R3: a newly set mark is always caused by a write or upgrade snoop
  p_read_no_mark_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((markVec & ~$past(markVec)) != '0) |->
      $past(snoopValid && (snoopKind == SNP_WRITE || snoopKind == SNP_UPGRADE)));
endmodule

// File: rtl/lqsr_ctrl.sv
module lqsr_ctrl
  import lqsr_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  input  logic             commitValid,
  input  logic [DEPTH-1:0] addrVec,
  input  logic [DEPTH-1:0] markVec,
  output lq_strobe_t       strobe,
  output logic [IW-1:0]    allocIdx,
  output logic [IW-1:0]    headIdx,
  output logic             full,
  output logic             empty,
  output logic             retireOk,
  output logic             flush
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] count;

  function automatic logic [IW-1:0] nextPtr(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + IW'(1);
  endfunction

  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign retireOk = commitValid && !empty && addrVec[headIdx] && !markVec[headIdx];
  assign flush    = commitValid && !empty && markVec[headIdx];

  always_comb begin
    strobe.clearAll = flush;
    strobe.retireEn = retireOk;
    strobe.allocEn  = allocValid && !full && !flush;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      allocIdx <= '0;
      headIdx  <= '0;
      count    <= '0;
    end else begin
      if (strobe.allocEn)  allocIdx <= nextPtr(allocIdx);
      if (strobe.retireEn) headIdx  <= nextPtr(headIdx);
      count <= count + CW'(strobe.allocEn) - CW'(strobe.retireEn);
    end
  end

  // R2: occupancy never exceeds the number of slots
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

  // R2: a reservation while full does not move the tail
  p_full_blocks_r2: assert property (@(posedge clk) disable iff (!rstN)
    (full && allocValid && !flush) |=> allocIdx == $past(allocIdx));

  // R9: a flush leaves an empty queue with reset pointers
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (empty && allocIdx == '0 && headIdx == '0));

  // R9: flush and retire never coincide
  p_flush_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(flush && retireOk));

  // R8: a retirement advances the head by one slot
  p_retire_adv_r8: assert property (@(posedge clk) disable iff (!rstN)
    retireOk |=> headIdx == nextPtr($past(headIdx)));

  // R10: without retire or flush the head stays put
  p_idle_head_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!retireOk && !flush) |=> $stable(headIdx));
endmodule

// File: rtl/lq_snoop_replay.sv
module lq_snoop_replay
  import lqsr_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int OFFW  = 4,
  parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          allocValid,
  output logic [IW-1:0] allocIdx,
  output logic          full,
  output logic          empty,
  output logic [IW-1:0] headIdx,
  input  logic          execValid,
  input  logic [IW-1:0] execIdx,
  input  logic [AW-1:0] execAddr,
  input  logic          snoopValid,
  input  logic [1:0]    snoopKind,
  input  logic [AW-1:0] snoopAddr,
  input  logic          commitValid,
  output logic          retireOk,
  output logic          flush
);
  lq_strobe_t       strobe;
  logic [DEPTH-1:0] addrVec, markVec;

  lqsr_ctrl #(.DEPTH(DEPTH), .IW(IW)) u_ctrl (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .commitValid(commitValid),
    .addrVec(addrVec), .markVec(markVec), .strobe(strobe),
    .allocIdx(allocIdx), .headIdx(headIdx), .full(full), .empty(empty),
    .retireOk(retireOk), .flush(flush)
  );

  lqsr_entries #(.DEPTH(DEPTH), .AW(AW), .OFFW(OFFW), .IW(IW)) u_entries (
    .clk(clk), .rstN(rstN), .strobe(strobe), .allocPtr(allocIdx), .retirePtr(headIdx),
    .execValid(execValid), .execIdx(execIdx), .execAddr(execAddr),
    .snoopValid(snoopValid), .snoopKind(snoopKind), .snoopAddr(snoopAddr),
    .addrVec(addrVec), .markVec(markVec)
  );
endmodule

// File: tb/lq_snoop_replay_tb.sv
module lq_snoop_replay_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int AW    = 16;
  localparam int OFFW  = 4;
  localparam int IW    = 2;

  logic clk = 1'b0;
  logic rstN;
  logic allocValid, execValid, snoopValid, commitValid;
  logic [IW-1:0] execIdx;
  logic [AW-1:0] execAddr, snoopAddr;
  logic [1:0] snoopKind;
  logic [IW-1:0] allocIdx, headIdx;
  logic full, empty, retireOk, flush;

  always #(CLK_PERIOD/2) clk = ~clk;

  lq_snoop_replay #(.DEPTH(DEPTH), .AW(AW), .OFFW(OFFW), .IW(IW)) u_dut (.*);

  int nChecks = 0, nFails = 0;
  string curReq = "R1";
  bit done = 0;

  // requirement model
  bit mBusy[DEPTH], mHas[DEPTH], mMark[DEPTH];
  int mLine[DEPTH];
  int mHead = 0, mTail = 0, mCnt = 0;

  task automatic chk(input string what, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", curReq, what, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int i = 0; i < DEPTH; i++) begin
      mBusy[i] = 0; mHas[i] = 0; mMark[i] = 0; mLine[i] = 0;
    end
    mHead = 0; mTail = 0; mCnt = 0;
  endtask

  // drive one cycle, check outputs, advance model
  task automatic step(input bit av, input bit ev, input int ei, input int ea,
                      input bit sv, input int sk, input int sa, input bit cv);
    bit expRet, expFl, mk;
    int sl;
    @(negedge clk);
    allocValid = av; execValid = ev; execIdx = IW'(ei); execAddr = AW'(ea);
    snoopValid = sv; snoopKind = 2'(sk); snoopAddr = AW'(sa); commitValid = cv;
    #1;
    expRet = cv && mCnt != 0 && mHas[mHead] && !mMark[mHead];
    expFl  = cv && mCnt != 0 && mMark[mHead];
    chk("empty",    int'(empty),    int'(mCnt == 0));
    chk("full",     int'(full),     int'(mCnt == DEPTH));
    chk("allocIdx", int'(allocIdx), mTail);
    chk("headIdx",  int'(headIdx),  mHead);
    chk("retireOk", int'(retireOk), int'(expRet));
    chk("flush",    int'(flush),    int'(expFl));
    @(posedge clk);
    if (expFl) begin
      modelClear();
    end else begin
      sl = (sa >> OFFW) & ((1 << (AW-OFFW)) - 1);
      mk = sv && (sk == 1 || sk == 2);
      for (int i = 0; i < DEPTH; i++) begin
        bit eh = ev && ei == i && mBusy[i];
        if (eh) begin mHas[i] = 1; mLine[i] = (ea >> OFFW) & ((1 << (AW-OFFW)) - 1); end
        if (mk && mBusy[i] && mHas[i] && mLine[i] == sl) mMark[i] = 1;
      end
      if (expRet) begin
        mBusy[mHead] = 0; mHas[mHead] = 0; mMark[mHead] = 0;
        mHead = (mHead + 1) % DEPTH; mCnt--;
      end
      if (av && mCnt < DEPTH && !(expRet && mCnt == DEPTH - 1 && 0)) begin
        if (mCnt < DEPTH - (expRet ? 1 : 0) + (expRet ? 1 : 0) && !(mCnt + (expRet ? 1 : 0) == DEPTH)) begin
          mBusy[mTail] = 1; mHas[mTail] = 0; mMark[mTail] = 0;
          mTail = (mTail + 1) % DEPTH; mCnt++;
        end
      end
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // commit until empty or stuck
  task automatic drain();
    for (int k = 0; k < 2*DEPTH && mCnt != 0; k++) step(0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    int lf;
    rstN = 0; allocValid = 0; execValid = 0; execIdx = 0; execAddr = 0;
    snoopValid = 0; snoopKind = 0; snoopAddr = 0; commitValid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    modelClear();

    curReq = "R1"; step(0, 0, 0, 0, 0, 0, 0, 1);

    // R2: fill past capacity, then R10 commit of unexecuted head
    curReq = "R2";
    for (int k = 0; k < DEPTH + 2; k++) step(1, 0, 0, 0, 0, 0, 0, 0);
    curReq = "R10"; step(0, 0, 0, 0, 0, 0, 0, 1); step(0, 0, 0, 0, 0, 0, 0, 1);
    // R6: snoop before execute, then execute same line
    curReq = "R6";
    step(0, 0, 0, 0, 1, 1, 16'h0120, 0);
    step(0, 1, 0, 16'h0124, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    // R7: execute and snoop same cycle
    curReq = "R7";
    step(0, 1, 1, 16'h0340, 1, 2, 16'h034F, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0);

    // R3/R4 sweep: each kind against each offset, two of four slots on the hit line
    for (int kind = 0; kind < 4; kind++) begin
      for (int off = 0; off < (1 << OFFW); off++) begin
        curReq = "R3";
        for (int k = 0; k < DEPTH; k++) step(1, 0, 0, 0, 0, 0, 0, 0);
        for (int k = 0; k < DEPTH; k++)
          step(0, 1, (mHead + k) % DEPTH, ((k % 2) ? 16'h0050 : 16'h0070) + k, 0, 0, 0, 0);
        curReq = "R4";
        step(0, 0, 0, 0, 1, kind, 16'h0070 + off, 0);
        curReq = "R5";
        step(0, 0, 0, 0, 1, kind, 16'h0060 + off, 0);
        curReq = (kind == 1 || kind == 2) ? "R9" : "R8";
        drain();
      end
    end

    // wrap-around run with mostly-unmarked loads
    curReq = "R8";
    for (int k = 0; k < 3*DEPTH; k++) begin
      step(1, 0, 0, 0, 0, 0, 0, 0);
      step(0, 1, (mTail + DEPTH - 1) % DEPTH, 16'h0800 + 16*k, 0, 0, 0, 0);
      step(0, 0, 0, 0, 1, 0, 16'h0800 + 16*k, 1);
    end
    // R9: flush with simultaneous allocation
    curReq = "R9";
    step(1, 0, 0, 0, 0, 0, 0, 0);
    step(0, 1, mHead, 16'h0900, 1, 1, 16'h0900, 0);
    step(1, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0);

    // pseudo-random stimulus over a few lines
    curReq = "R5";
    lf = 32'h1ACE;
    for (int k = 0; k < 4000; k++) begin
      int r;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (lf == 0) lf = 1;
      r = lf;
      step(r[0] | r[1], r[2], r[4:3], {r[6:5], 4'h0} + r[10:7], r[11] & r[12],
           r[14:13], {r[16:15], 4'h0} + r[20:17], r[21] & r[22]);
    end

    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    end
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule